// File: doc/BRIEF.md
# Two-Way Write-Through Cache Controller With Read-Under-Write

This block is the control, tag and replacement logic of a small byte-wide cache that sits between a processor request port and a slow main memory. The cache is two-way set-associative. Every way holds one byte, a tag and a valid flag, and each set keeps one replacement bit. An address is split into a set index in its upper bits and a tag in its lower bits. A lookup compares the tag against both ways of the selected set at the same time.

Writes are write-through. A write updates the cache at once and starts a memory write that takes several cycles to finish. While that memory write is outstanding, the controller keeps serving reads that hit. It accepts a first read that hits, and then a second read that hits. A third request is held off. So is a read that misses, and so is another write. A read that misses while memory is idle fetches the byte from memory, fills a way and returns the byte. The processor keeps a request asserted until `cpu_busy` is low at a rising edge. If read and write are asserted together, the write is taken.

Controller states: `CS_IDLE` (no memory traffic), `CS_FILL` (a read miss is waiting for memory data), `CS_WT_OPEN` (a write is outstanding and no read has been served), `CS_WT_ONE` (a write is outstanding and one read hit has been served), `CS_WT_FULL` (a write is outstanding and two read hits have been served). The transitions are:
- `CS_IDLE` goes to `CS_WT_OPEN` on a write and to `CS_FILL` on a read miss. A read hit keeps it in `CS_IDLE`.
- `CS_FILL` returns to `CS_IDLE` on `mem_ack`.
- `CS_WT_OPEN` moves to `CS_WT_ONE` on a read hit, and `CS_WT_ONE` moves to `CS_WT_FULL` on a read hit.
- `CS_WT_OPEN`, `CS_WT_ONE` and `CS_WT_FULL` all return to `CS_IDLE` on `mem_ack`.

Top module: `wt_cache`

## Requirements
- R1: After reset every way is invalid, `cpu_busy`, `cpu_rvalid` and `mem_req` are low, and the first read of any address misses.
- R2: The set index is the upper `SET_W` address bits and the tag is the lower `TAG_W` bits (bits [4:3] and [2:0] at defaults). An access hits only if a valid way of its own set holds its tag.
- R3: A read that hits and is accepted at a rising edge raises `cpu_rvalid` with the stored byte on `cpu_rdata` for the next cycle, and starts no memory read.
- R4: A read miss accepted while memory is idle drives `mem_req` high with `mem_we` low and the read address from the next cycle until `mem_ack`. `cpu_busy` stays high meanwhile, and the cycle after `mem_ack` presents the memory byte with `cpu_rvalid`.
- R5: A fill or write allocation goes to way 0 if that way is invalid, otherwise to way 1 if that way is invalid, otherwise to the way named by the set's replacement bit.
- R6: Every hit, fill or write allocation sets the set's replacement bit to the way that was not touched.
- R7: An accepted write updates the matching way on a hit and allocates a way on a miss. From the next cycle it drives `mem_req` and `mem_we` high, with the same address and data, until `mem_ack`.
- R8: While a write to memory is outstanding, a read that hits is accepted without stalling and is answered before the write completes.
- R9: While a write is outstanding, a second read hit is accepted only after a first one. Any third request holds `cpu_busy` high until the write completes.
- R10: While a write is outstanding, a read that misses, or another write, holds `cpu_busy` high until the write completes.
- R11: The two valid ways of any set never hold the same tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_rd | input | 1 | Read request, held until accepted |
| cpu_wr | input | 1 | Write request, held until accepted |
| cpu_addr | input | SET_W+TAG_W | Request address (set index high, tag low) |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_rvalid` |
| cpu_rvalid | output | 1 | One-cycle read data strobe |
| cpu_busy | output | 1 | Request cannot be accepted this cycle |
| mem_req | output | 1 | Memory transaction pending, held until `mem_ack` |
| mem_we | output | 1 | Pending transaction is a write |
| mem_addr | output | SET_W+TAG_W | Memory transaction address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory done / read data available (one-cycle pulse) |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |

## Verification
The bench uses the default parameters: four sets, a 3-bit tag and byte data. That gives a 32-byte address space, so every address is swept both cold and warm, and every set runs through fill, hit and eviction orderings against an arithmetic reference model. The memory latency in the bench is long enough that two read hits and a stalled third request all fall inside one outstanding write. This brings the read-under-write limit and the busy stalls for misses and writes within reach.

// File: rtl/wt_cache_pkg.sv
package wt_cache_pkg;

    // Controller states
    typedef enum logic [2:0] {
        CS_IDLE,      // no memory traffic
        CS_FILL,      // read miss waiting for memory byte
        CS_WT_OPEN,   // write outstanding, no read served
        CS_WT_ONE,    // write outstanding, one read hit served
        CS_WT_FULL    // write outstanding, two read hits served
    } cs_state_e;

endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
    parameter int SETS  = 4,
    parameter int TAG_W = 3,
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic             lk_way,
    output logic [1:0]       lk_valid,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_set,
    input  logic             wr_way,
    input  logic [TAG_W-1:0] wr_tag
);

    logic [TAG_W-1:0] tag_q [SETS][2];
    logic [1:0]       vld_q [SETS];
    logic [1:0]       way_match;

    // Parallel compare across both ways of the selected set
    for (genvar w = 0; w < 2; w++) begin : g_cmp
        assign way_match[w] = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
    end

    assign lk_hit   = |way_match;
    assign lk_way   = way_match[1];
    assign lk_valid = vld_q[lk_set];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= 2'b00;
            end
        end else if (wr_en) begin
            vld_q[wr_set][wr_way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_set][wr_way] <= wr_tag;
        end
    end

endmodule

// File: rtl/wtc_data_store.sv
module wtc_data_store #(
    parameter int SETS   = 4,
    parameter int DATA_W = 8,
    localparam int SET_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic [SET_W-1:0]  rd_set,
    input  logic              rd_way,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [SET_W-1:0]  wr_set,
    input  logic              wr_way,
    input  logic [DATA_W-1:0] wr_data
);

    logic [DATA_W-1:0] byte_q [SETS][2];

    assign rd_data = byte_q[rd_set][rd_way];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            byte_q[wr_set][wr_way] <= wr_data;
        end
    end

endmodule

// File: rtl/wtc_lru.sv
module wtc_lru #(
    parameter int SETS = 4,
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] q_set,
    input  logic [1:0]       q_valid,
    output logic             victim,
    input  logic             touch_en,
    input  logic [SET_W-1:0] touch_set,
    input  logic             touch_way
);

    // One bit per set naming the least recently used way
    logic [SETS-1:0] lru_q;

    always_comb begin
        if (!q_valid[0]) begin
            victim = 1'b0;
        end else if (!q_valid[1]) begin
            victim = 1'b1;
        end else begin
            victim = lru_q[q_set];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lru_q <= '0;
        end else if (touch_en) begin
            lru_q[touch_set] <= ~touch_way;
        end
    end

endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
    import wt_cache_pkg::*;
#(
    parameter int SET_W  = 2,
    parameter int TAG_W  = 3,
    parameter int DATA_W = 8,
    localparam int ADDR_W = SET_W + TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_rvalid,
    output logic              cpu_busy,
    input  logic              lk_hit,
    input  logic              lk_way,
    input  logic [DATA_W-1:0] lk_data,
    input  logic              victim,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              upd_tag_en,
    output logic              upd_data_en,
    output logic              upd_touch_en,
    output logic [SET_W-1:0]  upd_set,
    output logic              upd_way,
    output logic [TAG_W-1:0]  upd_tag,
    output logic [DATA_W-1:0] upd_data
);

    cs_state_e state_q, state_d;

    logic              busy;
    logic              wr_ok;
    logic              rd_hit_ok;
    logic              rd_miss_ok;
    logic              fill_done;
    logic [SET_W-1:0]  cur_set;
    logic [TAG_W-1:0]  cur_tag;

    logic [SET_W-1:0]  fill_set_q;
    logic [TAG_W-1:0]  fill_tag_q;
    logic              fill_way_q;
    logic              req_q;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rvalid_q;

    assign cur_set = cpu_addr[ADDR_W-1 -: SET_W];
    assign cur_tag = cpu_addr[TAG_W-1:0];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state, acceptance and update controls
    always_comb begin
        state_d    = state_q;
        busy       = 1'b0;
        wr_ok      = 1'b0;
        rd_hit_ok  = 1'b0;
        rd_miss_ok = 1'b0;
        fill_done  = 1'b0;
        unique case (state_q)
            CS_IDLE: begin
                wr_ok      = cpu_wr;
                rd_hit_ok  = cpu_rd && !cpu_wr && lk_hit;
                rd_miss_ok = cpu_rd && !cpu_wr && !lk_hit;
                if (wr_ok) begin
                    state_d = CS_WT_OPEN;
                end else if (rd_miss_ok) begin
                    state_d = CS_FILL;
                end
            end
            CS_FILL: begin
                busy      = 1'b1;
                fill_done = mem_ack;
                if (mem_ack) begin
                    state_d = CS_IDLE;
                end
            end
            CS_WT_OPEN: begin
                busy      = cpu_wr || (cpu_rd && !lk_hit);
                rd_hit_ok = cpu_rd && !cpu_wr && lk_hit;
                if (mem_ack) begin
                    state_d = CS_IDLE;
                end else if (rd_hit_ok) begin
                    state_d = CS_WT_ONE;
                end
            end
            CS_WT_ONE: begin
                busy      = cpu_wr || (cpu_rd && !lk_hit);
                rd_hit_ok = cpu_rd && !cpu_wr && lk_hit;
                if (mem_ack) begin
                    state_d = CS_IDLE;
                end else if (rd_hit_ok) begin
                    state_d = CS_WT_FULL;
                end
            end
            CS_WT_FULL: begin
                busy = 1'b1;
                if (mem_ack) begin
                    state_d = CS_IDLE;
                end
            end
            default: begin
                state_d = CS_IDLE;
            end
        endcase

        upd_tag_en   = 1'b0;
        upd_data_en  = 1'b0;
        upd_touch_en = 1'b0;
        upd_set      = cur_set;
        upd_way      = lk_way;
        upd_tag      = cur_tag;
        upd_data     = cpu_wdata;
        if (fill_done) begin
            upd_tag_en   = 1'b1;
            upd_data_en  = 1'b1;
            upd_touch_en = 1'b1;
            upd_set      = fill_set_q;
            upd_way      = fill_way_q;
            upd_tag      = fill_tag_q;
            upd_data     = mem_rdata;
        end else if (wr_ok) begin
            upd_tag_en   = 1'b1;
            upd_data_en  = 1'b1;
            upd_touch_en = 1'b1;
            upd_way      = lk_hit ? lk_way : victim;
        end else if (rd_hit_ok) begin
            upd_touch_en = 1'b1;
        end
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q      <= 1'b0;
            we_q       <= 1'b0;
            addr_q     <= '0;
            wdata_q    <= '0;
            rdata_q    <= '0;
            rvalid_q   <= 1'b0;
            fill_set_q <= '0;
            fill_tag_q <= '0;
            fill_way_q <= 1'b0;
        end else begin
            rvalid_q <= rd_hit_ok || fill_done;
            if (fill_done) begin
                rdata_q <= mem_rdata;
            end else if (rd_hit_ok) begin
                rdata_q <= lk_data;
            end
            if (req_q && mem_ack) begin
                req_q <= 1'b0;
            end
            if (wr_ok) begin
                req_q   <= 1'b1;
                we_q    <= 1'b1;
                addr_q  <= cpu_addr;
                wdata_q <= cpu_wdata;
            end else if (rd_miss_ok) begin
                req_q      <= 1'b1;
                we_q       <= 1'b0;
                addr_q     <= cpu_addr;
                fill_set_q <= cur_set;
                fill_tag_q <= cur_tag;
                fill_way_q <= victim;
            end
        end
    end

    assign cpu_busy   = busy;
    assign cpu_rdata  = rdata_q;
    assign cpu_rvalid = rvalid_q;
    assign mem_req    = req_q;
    assign mem_we     = we_q;
    assign mem_addr   = addr_q;
    assign mem_wdata  = wdata_q;

endmodule

// File: rtl/wt_cache.sv
module wt_cache #(
    parameter int SETS   = 4,
    parameter int TAG_W  = 3,
    parameter int DATA_W = 8,
    localparam int SET_W  = $clog2(SETS),
    localparam int ADDR_W = SET_W + TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_rvalid,
    output logic              cpu_busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);

    logic [SET_W-1:0]  lookup_set;
    logic [TAG_W-1:0]  lookup_tag;
    logic              lookup_hit;
    logic              lookup_way;
    logic [1:0]        lookup_valid;
    logic [DATA_W-1:0] lookup_data;
    logic              victim_way;

    logic              upd_tag_en;
    logic              upd_data_en;
    logic              upd_touch_en;
    logic [SET_W-1:0]  upd_set;
    logic              upd_way;
    logic [TAG_W-1:0]  upd_tag;
    logic [DATA_W-1:0] upd_data;

    assign lookup_set = cpu_addr[ADDR_W-1 -: SET_W];
    assign lookup_tag = cpu_addr[TAG_W-1:0];

    wtc_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_set   (lookup_set),
        .lk_tag   (lookup_tag),
        .lk_hit   (lookup_hit),
        .lk_way   (lookup_way),
        .lk_valid (lookup_valid),
        .wr_en    (upd_tag_en),
        .wr_set   (upd_set),
        .wr_way   (upd_way),
        .wr_tag   (upd_tag)
    );

    wtc_data_store #(.SETS(SETS), .DATA_W(DATA_W)) u_data (
        .clk     (clk),
        .rd_set  (lookup_set),
        .rd_way  (lookup_way),
        .rd_data (lookup_data),
        .wr_en   (upd_data_en),
        .wr_set  (upd_set),
        .wr_way  (upd_way),
        .wr_data (upd_data)
    );

    wtc_lru #(.SETS(SETS)) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .q_set     (lookup_set),
        .q_valid   (lookup_valid),
        .victim    (victim_way),
        .touch_en  (upd_touch_en),
        .touch_set (upd_set),
        .touch_way (upd_way)
    );

    wtc_ctrl #(.SET_W(SET_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_rd       (cpu_rd),
        .cpu_wr       (cpu_wr),
        .cpu_addr     (cpu_addr),
        .cpu_wdata    (cpu_wdata),
        .cpu_rdata    (cpu_rdata),
        .cpu_rvalid   (cpu_rvalid),
        .cpu_busy     (cpu_busy),
        .lk_hit       (lookup_hit),
        .lk_way       (lookup_way),
        .lk_data      (lookup_data),
        .victim       (victim_way),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_ack      (mem_ack),
        .mem_rdata    (mem_rdata),
        .upd_tag_en   (upd_tag_en),
        .upd_data_en  (upd_data_en),
        .upd_touch_en (upd_touch_en),
        .upd_set      (upd_set),
        .upd_way      (upd_way),
        .upd_tag      (upd_tag),
        .upd_data     (upd_data)
    );

endmodule

// File: rtl/wt_cache_chk.sv
module wt_cache_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_rd,
    input logic              cpu_wr,
    input logic              cpu_busy,
    input logic              cpu_rvalid,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic              mem_req,
    input logic              mem_we,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ack,
    input logic              lookup_hit
);

    logic       wr_open;
    logic [1:0] reads_in_write;

    assign wr_open = mem_req && mem_we;

    always_ff @(posedge clk) begin
        if (!rst_n || !wr_open) begin
            reads_in_write <= 2'd0;
        end else if (cpu_rd && !cpu_wr && !cpu_busy && reads_in_write != 2'd3) begin
            reads_in_write <= reads_in_write + 2'd1;
        end
    end

    assert_hit_answers_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cpu_wr && !cpu_busy && lookup_hit) |=> cpu_rvalid);

    assert_miss_fetches_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cpu_wr && !cpu_busy && !lookup_hit) |=> (mem_req && !mem_we));

    assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req);

    assert_write_through_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !cpu_busy) |=> (mem_req && mem_we && mem_wdata == $past(cpu_wdata)));

    assert_read_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reads_in_write <= 2'd2);

    assert_pending_hit_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_open && cpu_rd && !cpu_busy) |-> lookup_hit);

endmodule

module wtc_tag_chk #(
    parameter int SETS  = 4,
    parameter int TAG_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [TAG_W-1:0] tags [SETS][2],
    input logic [1:0]       vld  [SETS]
);

    always @(posedge clk) begin
        if (rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                assert_tags_differ_R11: assert (!(vld[s] == 2'b11 && tags[s][0] == tags[s][1]))
                    else $error("set %0d holds a duplicated tag", s);
            end
        end
    end

endmodule

bind wt_cache wt_cache_chk #(.DATA_W(DATA_W)) u_cache_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_rd     (cpu_rd),
    .cpu_wr     (cpu_wr),
    .cpu_busy   (cpu_busy),
    .cpu_rvalid (cpu_rvalid),
    .cpu_wdata  (cpu_wdata),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .lookup_hit (lookup_hit)
);

bind wtc_tag_store wtc_tag_chk #(.SETS(SETS), .TAG_W(TAG_W)) u_tag_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .tags  (tag_q),
    .vld   (vld_q)
);

// File: tb/wt_cache_tb.sv
module wt_cache_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int SETS       = 4;
    localparam int TAG_W      = 3;
    localparam int DATA_W     = 8;
    localparam int SET_W      = $clog2(SETS);
    localparam int ADDR_W     = SET_W + TAG_W;
    localparam int NADDR      = 1 << ADDR_W;
    localparam int MEM_LAT    = 8;
    localparam int WD_CYCLES  = 150000;

    logic              clk;
    logic              rst_n;
    logic              cpu_rd;
    logic              cpu_wr;
    logic [ADDR_W-1:0] cpu_addr;
    logic [DATA_W-1:0] cpu_wdata;
    logic [DATA_W-1:0] cpu_rdata;
    logic              cpu_rvalid;
    logic              cpu_busy;
    logic              mem_req;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic              mem_ack;
    logic [DATA_W-1:0] mem_rdata;

    wt_cache #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_rd     (cpu_rd),
        .cpu_wr     (cpu_wr),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_rdata  (cpu_rdata),
        .cpu_rvalid (cpu_rvalid),
        .cpu_busy   (cpu_busy),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DATA_W-1:0] init_byte(input int a);
        return DATA_W'((a * 37 + 11) & 8'hFF);
    endfunction

    // Main memory model: fixed latency, one transaction at a time
    logic [DATA_W-1:0] mem [NADDR];
    int                lat_cnt;
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            lat_cnt   <= 0;
            for (int a = 0; a < NADDR; a++) mem[a] <= init_byte(a);
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (lat_cnt == MEM_LAT - 1) begin
                mem_ack <= 1'b1;
                lat_cnt <= 0;
                if (mem_we) mem[mem_addr] <= mem_wdata;
                else        mem_rdata     <= mem[mem_addr];
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end
    end

    // Reference model
    logic [TAG_W-1:0]  ref_tag [SETS][2];
    logic [1:0]        ref_vld [SETS];
    logic              ref_lru [SETS];
    logic [DATA_W-1:0] ref_dat [SETS][2];
    logic [DATA_W-1:0] exp_mem [NADDR];

    int n_checks;
    int n_fail;

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int ref_find(input int a);
        int s;
        s = a >> TAG_W;
        for (int w = 0; w < 2; w++)
            if (ref_vld[s][w] && ref_tag[s][w] == TAG_W'(a)) return w;
        return -1;
    endfunction

    task automatic ref_access(input int a, input logic [DATA_W-1:0] d, input bit is_wr);
        int s;
        int w;
        s = a >> TAG_W;
        w = ref_find(a);
        if (w >= 0) begin
            if (is_wr) ref_dat[s][w] = d;
        end else begin
            if (!ref_vld[s][0])      w = 0;
            else if (!ref_vld[s][1]) w = 1;
            else                     w = int'(ref_lru[s]);
            ref_vld[s][w] = 1'b1;
            ref_tag[s][w] = TAG_W'(a);
            ref_dat[s][w] = d;
        end
        ref_lru[s] = (w == 0);
    endtask

    task automatic do_read(input int a, input string cls_req, output int stalls, output bit req_at_acc);
        bit                exp_hit;
        bit                obs_hit;
        logic [DATA_W-1:0] exp_data;
        int                w;
        int                s;
        int                tmo;
        @(negedge clk);
        cpu_rd   = 1'b1;
        cpu_addr = ADDR_W'(a);
        stalls   = 0;
        #1;
        while (cpu_busy && stalls < 200) begin
            @(negedge clk);
            #1;
            stalls++;
        end
        req_at_acc = mem_req;
        s = a >> TAG_W;
        w = ref_find(a);
        exp_hit  = (w >= 0);
        exp_data = exp_hit ? ref_dat[s][w] : exp_mem[a];
        @(negedge clk);
        cpu_rd = 1'b0;
        obs_hit = !(mem_req && !mem_we);
        check_eq(cls_req, $sformatf("hit/miss of read addr %0d", a), int'(obs_hit), int'(exp_hit));
        if (exp_hit) begin
            check_eq("R3", "rvalid after read hit", int'(cpu_rvalid), 1);
            check_eq("R3", $sformatf("hit data addr %0d", a), int'(cpu_rdata), int'(exp_data));
        end else begin
            check_eq("R4", "fetch address", int'(mem_addr), a);
            check_eq("R4", "busy during fetch", int'(cpu_busy), 1);
            tmo = 0;
            while (!cpu_rvalid && tmo < 100) begin
                @(negedge clk);
                tmo++;
            end
            check_eq("R4", $sformatf("fill data addr %0d", a), int'(cpu_rdata), int'(exp_data));
        end
        ref_access(a, exp_data, 1'b0);
    endtask

    task automatic do_write(input int a, input logic [DATA_W-1:0] d, output int stalls, output bit req_at_acc);
        @(negedge clk);
        cpu_wr    = 1'b1;
        cpu_addr  = ADDR_W'(a);
        cpu_wdata = d;
        stalls    = 0;
        #1;
        while (cpu_busy && stalls < 200) begin
            @(negedge clk);
            #1;
            stalls++;
        end
        req_at_acc = mem_req;
        @(negedge clk);
        cpu_wr = 1'b0;
        check_eq("R7", "write request issued", int'(mem_req && mem_we), 1);
        check_eq("R7", "write address", int'(mem_addr), a);
        check_eq("R7", "write data", int'(mem_wdata), int'(d));
        exp_mem[a] = d;
        ref_access(a, d, 1'b1);
    endtask

    task automatic wait_quiet();
        int tmo;
        tmo = 0;
        @(negedge clk);
        while (mem_req && tmo < 100) begin
            @(negedge clk);
            tmo++;
        end
    endtask

    task automatic run_all();
        int  st;
        bit  rq;
        int  miss_a;
        logic [DATA_W-1:0] d;

        // R1: reset state
        @(negedge clk);
        check_eq("R1", "busy after reset", int'(cpu_busy), 0);
        check_eq("R1", "rvalid after reset", int'(cpu_rvalid), 0);
        check_eq("R1", "mem_req after reset", int'(mem_req), 0);

        // R1/R5: cold sweep, every address misses or evicts
        for (int a = 0; a < NADDR; a++) do_read(a, "R1", st, rq);

        // R2: warm sweep, hits only where own set holds own tag
        for (int a = NADDR - 1; a >= 0; a--) do_read(a, "R2", st, rq);

        // R5/R6: replacement ordering per set
        for (int s = 0; s < SETS; s++) begin
            int pat [7] = '{1, 2, 1, 3, 1, 2, 3};
            for (int i = 0; i < 7; i++) do_read((s << TAG_W) | pat[i], "R6", st, rq);
            do_read((s << TAG_W) | 5, "R5", st, rq);
            do_read((s << TAG_W) | 3, "R5", st, rq);
        end

        // R7: write sweep (hits and allocations), memory updated
        for (int a = 0; a < NADDR; a += 3) begin
            d = DATA_W'(a ^ 8'h5A);
            do_write(a, d, st, rq);
            wait_quiet();
            check_eq("R7", $sformatf("memory byte at %0d", a), int'(mem[a]), int'(d));
        end
        for (int a = 0; a < NADDR; a++) do_read(a, "R7", st, rq);

        // R8/R9: two read hits under a write, third stalls
        for (int k = 0; k < SETS; k++) begin
            int wa;
            wa = (k << TAG_W) | 6;
            wait_quiet();
            do_write(wa, DATA_W'(8'hC0 + k), st, rq);
            do_read(wa, "R8", st, rq);
            check_eq("R8", "first hit not stalled", st, 0);
            check_eq("R8", "first hit served during write", int'(rq && mem_we), 1);
            do_read(wa, "R9", st, rq);
            check_eq("R9", "second hit not stalled", st, 0);
            check_eq("R9", "second hit served during write", int'(rq), 1);
            do_read(wa, "R9", st, rq);
            check_eq("R9", "third request stalled", int'(st > 0), 1);
            check_eq("R9", "third request after write done", int'(rq), 0);
        end

        // R10: read miss and second write under a write
        for (int k = 0; k < SETS; k++) begin
            int wa;
            wa = (k << TAG_W) | 1;
            wait_quiet();
            do_write(wa, DATA_W'(8'h33 + k), st, rq);
            miss_a = -1;
            for (int t = 0; t < (1 << TAG_W); t++)
                if (miss_a < 0 && ref_find((k << TAG_W) | t) < 0) miss_a = (k << TAG_W) | t;
            do_read(miss_a, "R10", st, rq);
            check_eq("R10", "read miss stalled", int'(st > 0), 1);
            check_eq("R10", "read miss after write done", int'(rq), 0);
            wait_quiet();
            do_write(wa, DATA_W'(8'h70 + k), st, rq);
            do_write(wa ^ 2, DATA_W'(8'h90 + k), st, rq);
            check_eq("R10", "second write stalled", int'(st > 0), 1);
            check_eq("R10", "second write after first done", int'(rq), 0);
        end
        wait_quiet();
        for (int a = 0; a < NADDR; a++) do_read(a, "R7", st, rq);
    endtask

    initial begin
        bit timed_out;
        n_checks  = 0;
        n_fail    = 0;
        timed_out = 1'b0;
        cpu_rd    = 1'b0;
        cpu_wr    = 1'b0;
        cpu_addr  = '0;
        cpu_wdata = '0;
        rst_n     = 1'b0;
        for (int s = 0; s < SETS; s++) begin
            ref_vld[s] = 2'b00;
            ref_lru[s] = 1'b0;
            for (int w = 0; w < 2; w++) begin
                ref_tag[s][w] = '0;
                ref_dat[s][w] = '0;
            end
        end
        for (int a = 0; a < NADDR; a++) exp_mem[a] = init_byte(a);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        fork
            run_all();
            begin
                repeat (WD_CYCLES) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R1: actual=timeout expected=completion");
        end
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule